// File: doc/BRIEF.md
# Contact Smart Card Session Sequencer

This block is the digital control core of a single-slot contact smart card interface. A host drives a small set of level controls: an active-low power command, a reset request, a supply voltage select, a power-down request, a clock-mode select, a divider select and a chip select. The card socket supplies two presence switches, one of each polarity, and the analog side supplies a supply-good status and fault flags for over-current, supply drop and over-temperature. From these inputs the block steps the card through a power-up and power-down sequence. It enables the supply, the I/O line and the card clock, and it releases card reset. It also drives one active-low, open-drain-style interrupt line.

The interrupt has two meanings. While the power command is inactive, a low level means no card is in the socket. While the power command is active, a low level means a fault stopped the session. Any fault during a session starts an automatic shutdown. After a fault, the card cannot be powered again until the host takes the power command high and then low again. When chip select is low, the block holds every host input at its last value, floats the interrupt and closes the host data path.

Top module: `card_seq_ctrl`

## Requirements
- R1: A session starts, with the supply enable rising, only when the power command is low and a card is present. With no card present, a low power command leaves every card output inactive.
- R2: Outside a session (power command high), the interrupt pulls low exactly when no card is present.
- R3: During a session, card removal, over-current, supply drop or over-temperature starts a shutdown. The interrupt then stays pulled low for as long as the power command stays low.
- R4: In the running state, card reset equals the host reset input. Before the sequence reaches that state, card reset is held low.
- R5: Power-up order, observed as {supply, io_en, clk_en, io_force_low}: 1000, then 1100, then 1110. Each step after the supply waits STEP_CYC cycles. Card reset follows only after the clock step.
- R6: Shutdown order from a running card: reset low, then 1100 (clock stopped), then 1001 (I/O forced low), then 0001 (supply off), then 0000 (idle). Each step lasts STEP_CYC cycles.
- R7: While chip select is low, the host inputs are frozen at their last values, the interrupt output enable is low and the host data path enable is low.
- R8: A power-down request gives pd_mode high only when idle with the power command high. The request is ignored while the power command is low.
- R9: When clock-mode select is high, the clock source output selects the external strobe. Card reset then follows the host reset input from the I/O enable step onward.
- R10: Either presence input indicates a card: pres_hi high or pres_lo_n low.
- R11: After a fault shutdown, the power command held low does not restart a session. Taking it high and then low again does.
- R12: If supply-good is not seen within VCC_TMO_CYC cycles of the supply enable, a fault shutdown follows (1000, 1001, 0001, 0000) and the interrupt pulls low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select; low freezes the host inputs and floats the outputs to the host |
| pwr_cmd_n | input | 1 | Active-low card power command |
| rst_in | input | 1 | Host card reset request |
| vsel_5v | input | 1 | 1 selects the higher card supply voltage |
| pwr_down | input | 1 | Power-down request |
| clk_mode_sync | input | 1 | 1 selects synchronous (strobe-clocked) card mode |
| div_sel | input | 2 | Card clock divider select, passed to the divider |
| pres_hi | input | 1 | Presence switch, active high |
| pres_lo_n | input | 1 | Presence switch, active low |
| vcc_ok | input | 1 | Card supply within range |
| flt_ovc | input | 1 | Over-current fault |
| flt_vdrop | input | 1 | Supply drop fault |
| flt_therm | input | 1 | Over-temperature fault |
| vcc_en | output | 1 | Card supply enable |
| vcc_sel_5v | output | 1 | Held voltage select to the converter |
| clk_en | output | 1 | Card clock enable request |
| clk_from_strobe | output | 1 | Card clock source is the external strobe |
| clk_div_sel | output | 2 | Held divider select |
| io_en | output | 1 | Card I/O enable |
| io_force_low | output | 1 | Force card I/O low during shutdown |
| card_rst | output | 1 | Card reset contact |
| host_path_en | output | 1 | Host data path pass enable (low means weak pull-up) |
| irq_drive_low | output | 1 | Pull the interrupt line low |
| irq_oe | output | 1 | Interrupt driver enabled (low means high impedance) |
| pd_mode | output | 1 | Low-power mode active |

## Verification
A wrong sequencer state shows up first in the order of the supply, I/O and clock enables, or in the spacing between them. The scoreboard compares every change of that four-bit group against the expected order, so a skipped or reordered step is caught on the very cycle it changes. A lost fault or re-arm flag shows at the interrupt or as a missing or spurious supply enable within a few cycles of the synchroniser delay. Missing freeze logic shows up as soon as the power command is changed under a low chip select.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VUP,
        ST_IOON,
        ST_CLKON,
        ST_RUN,
        ST_DRST,
        ST_DCLK,
        ST_DIO,
        ST_DVCC
    } seq_st_e;

    localparam int HOST_W = 7;
    // host bundle bit positions
    localparam int HB_CMD  = 6;
    localparam int HB_RST  = 5;
    localparam int HB_VSEL = 4;
    localparam int HB_PD   = 3;
    localparam int HB_MODE = 2;
    localparam logic [HOST_W-1:0] HOST_RST_VAL = 7'b101_0000;
endpackage

// File: rtl/sync_stages.sv
module sync_stages #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= din;
                else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/host_hold.sv
module host_hold
    import card_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic [HOST_W-1:0] live,
    output logic [HOST_W-1:0] held
);
    logic [HOST_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = cs ? live : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= HOST_RST_VAL;
        else        hold_q <= hold_d;
    end

    assign held = cs ? live : hold_q;

    // R7
    frozen_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && $past(!cs)) |-> (held == $past(held)));
endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
    import card_seq_pkg::*;
#(
    parameter int STEP_CYC    = 8,
    parameter int VCC_TMO_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_n,
    input  logic rst_req,
    input  logic pd_req,
    input  logic sync_mode,
    input  logic present,
    input  logic supply_good,
    input  logic fault_any,
    output logic vcc_en,
    output logic io_en,
    output logic io_low,
    output logic clk_en,
    output logic card_rst,
    output logic fault_flag,
    output logic pd_mode
);
    localparam int MAXC = (STEP_CYC > VCC_TMO_CYC) ? STEP_CYC : VCC_TMO_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(VCC_TMO_CYC - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          fault;
        logic          armed;
        logic          pd;
        logic          vcc;
        logic          io;
        logic          ck;
        logic          iolow;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic in_sess, step_done;

    always_comb begin
        r_d       = r_q;
        r_d.cnt   = r_q.cnt + 1'b1;
        in_sess   = r_q.st inside {ST_VUP, ST_IOON, ST_CLKON, ST_RUN};
        step_done = (r_q.cnt == STEP_LAST);
        if (cmd_n) begin
            r_d.armed = 1'b1;
            r_d.fault = 1'b0;
        end
        if (in_sess && (fault_any || !present)) begin
            r_d.fault = 1'b1;
            r_d.armed = 1'b0;
            r_d.st    = ST_DRST;
            r_d.cnt   = '0;
        end else if (in_sess && cmd_n) begin
            r_d.st  = ST_DRST;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.cnt   = '0;
                    r_d.iolow = 1'b0;
                    r_d.pd    = pd_req && cmd_n;
                    if (!cmd_n && present && r_q.armed) begin
                        r_d.st  = ST_VUP;
                        r_d.vcc = 1'b1;
                        r_d.pd  = 1'b0;
                    end
                end
                ST_VUP: begin
                    if (supply_good) begin
                        r_d.st  = ST_IOON;
                        r_d.io  = 1'b1;
                        r_d.cnt = '0;
                    end else if (r_q.cnt == TMO_LAST) begin
                        r_d.fault = 1'b1;
                        r_d.armed = 1'b0;
                        r_d.st    = ST_DRST;
                        r_d.cnt   = '0;
                    end
                end
                ST_IOON: if (step_done) begin
                    r_d.st  = ST_CLKON;
                    r_d.ck  = 1'b1;
                    r_d.cnt = '0;
                end
                ST_CLKON: if (step_done) begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                end
                ST_RUN: r_d.cnt = '0;
                ST_DRST: if (step_done) begin
                    r_d.st  = ST_DCLK;
                    r_d.ck  = 1'b0;
                    r_d.cnt = '0;
                end
                ST_DCLK: if (step_done) begin
                    r_d.st    = ST_DIO;
                    r_d.io    = 1'b0;
                    r_d.iolow = 1'b1;
                    r_d.cnt   = '0;
                end
                ST_DIO: if (step_done) begin
                    r_d.st  = ST_DVCC;
                    r_d.vcc = 1'b0;
                    r_d.cnt = '0;
                end
                ST_DVCC: if (step_done) begin
                    r_d.st    = ST_IDLE;
                    r_d.iolow = 1'b0;
                    r_d.cnt   = '0;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.armed <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign vcc_en     = r_q.vcc;
    assign io_en      = r_q.io;
    assign clk_en     = r_q.ck;
    assign io_low     = r_q.iolow;
    assign fault_flag = r_q.fault;
    assign pd_mode    = r_q.pd;
    assign card_rst   = rst_req && (sync_mode ? (r_q.st inside {ST_IOON, ST_CLKON, ST_RUN})
                                              : (r_q.st == ST_RUN));

    // R5
    io_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n) io_en |-> vcc_en);
    // R5
    clk_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n) clk_en |-> io_en);
    // R4
    rst_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n) card_rst |-> vcc_en);
    // R6
    idle_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_IDLE) |-> ($past(r_q.st) == ST_DVCC && !vcc_en));
    // R3
    fault_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sess && fault_any) |=> (r_q.st == ST_DRST && fault_flag));
    // R8
    pd_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_mode |-> (r_q.st == ST_IDLE && !vcc_en));
endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
    import card_seq_pkg::*;
#(
    parameter int STEP_CYC    = 8,
    parameter int VCC_TMO_CYC = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       pwr_cmd_n,
    input  logic       rst_in,
    input  logic       vsel_5v,
    input  logic       pwr_down,
    input  logic       clk_mode_sync,
    input  logic [1:0] div_sel,
    input  logic       pres_hi,
    input  logic       pres_lo_n,
    input  logic       vcc_ok,
    input  logic       flt_ovc,
    input  logic       flt_vdrop,
    input  logic       flt_therm,
    output logic       vcc_en,
    output logic       vcc_sel_5v,
    output logic       clk_en,
    output logic       clk_from_strobe,
    output logic [1:0] clk_div_sel,
    output logic       io_en,
    output logic       io_force_low,
    output logic       card_rst,
    output logic       host_path_en,
    output logic       irq_drive_low,
    output logic       irq_oe,
    output logic       pd_mode
);
    localparam int SENSE_W = 5;

    logic [HOST_W-1:0]  host_live, host_q;
    logic [SENSE_W-1:0] sense_raw, sense_s;
    logic present_s, fault_s, fault_flag;

    assign host_live = {pwr_cmd_n, rst_in, vsel_5v, pwr_down, clk_mode_sync, div_sel};

    host_hold u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .cs   (cs),
        .live (host_live),
        .held (host_q)
    );

    // R10: either switch polarity reports a card
    assign sense_raw = {pres_hi | ~pres_lo_n, vcc_ok, flt_ovc, flt_vdrop, flt_therm};

    sync_stages #(.W(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sense_raw),
        .dout (sense_s)
    );

    assign present_s = sense_s[4];
    assign fault_s   = |sense_s[2:0];

    card_seq_fsm #(.STEP_CYC(STEP_CYC), .VCC_TMO_CYC(VCC_TMO_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_n      (host_q[HB_CMD]),
        .rst_req    (host_q[HB_RST]),
        .pd_req     (host_q[HB_PD]),
        .sync_mode  (host_q[HB_MODE]),
        .present    (present_s),
        .supply_good(sense_s[3]),
        .fault_any  (fault_s),
        .vcc_en     (vcc_en),
        .io_en      (io_en),
        .io_low     (io_force_low),
        .clk_en     (clk_en),
        .card_rst   (card_rst),
        .fault_flag (fault_flag),
        .pd_mode    (pd_mode)
    );

    assign vcc_sel_5v      = host_q[HB_VSEL];
    assign clk_from_strobe = host_q[HB_MODE];
    assign clk_div_sel     = host_q[1:0];
    assign host_path_en    = cs & io_en;
    assign irq_oe          = cs;
    // R2 / R3: meaning depends on the power command
    assign irq_drive_low   = cs & (host_q[HB_CMD] ? ~present_s : fault_flag);

    // R12
    supply_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_en && !io_en && !io_force_low && fault_flag) |=> !clk_en);
endmodule

// File: tb/tb_card_seq_ctrl.sv
module tb_card_seq_ctrl;
    localparam int STEP = 8;

    logic clk = 0, rst_n = 0;
    logic cs = 1, pwr_cmd_n = 1, rst_in = 0, vsel_5v = 1, pwr_down = 0, clk_mode_sync = 0;
    logic [1:0] div_sel = 2'b00;
    logic pres_hi = 0, pres_lo_n = 1, flt_ovc = 0, flt_vdrop = 0, flt_therm = 0;
    logic supply_model = 1;
    logic vcc_ok;
    logic vcc_en, vcc_sel_5v, clk_en, clk_from_strobe, io_en, io_force_low, card_rst;
    logic host_path_en, irq_drive_low, irq_oe, pd_mode;
    logic [1:0] clk_div_sel;
    logic [3:0] snap, prev_snap;

    int nchk = 0, nfail = 0;
    logic [3:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    assign vcc_ok = vcc_en & supply_model;
    assign snap   = {vcc_en, io_en, clk_en, io_force_low};

    card_seq_ctrl #(.STEP_CYC(STEP), .VCC_TMO_CYC(64)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic push_up(input string tag);
        push(4'b1000, tag); push(4'b1100, tag); push(4'b1110, tag);
    endtask

    task automatic push_down(input string tag);
        push(4'b1100, tag); push(4'b1001, tag); push(4'b0001, tag); push(4'b0000, tag);
    endtask

    // monitor: every change of the enable group is matched against the queue
    always @(negedge clk) begin
        if (rst_n && snap !== prev_snap) begin
            if (exp_q.size() == 0) chk(0, "R5/R6 unexpected step", int'(snap), -1);
            else begin
                string t;
                logic [3:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(snap === e, t, int'(snap), int'(e));
            end
        end
        prev_snap = snap;
    end

    task automatic wait_snap(input logic [3:0] v, input int maxc, input string req);
        bit seen = 0;
        for (int i = 0; i < maxc && !seen; i++) begin
            @(negedge clk);
            if (snap === v) seen = 1;
        end
        if (!seen) chk(0, req, int'(snap), int'(v));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic activate(input string tag);
        push_up(tag);
        pwr_cmd_n = 0;
        wait_snap(4'b1110, 200, tag);
        idle(STEP + 3);
    endtask

    task automatic run_all;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk(snap == 4'b0000, "R5 reset enables off", int'(snap), 0);
        chk(irq_drive_low == 1, "R2 reset no card irq", irq_drive_low, 1);
        chk(irq_oe == 1, "R7 reset irq driven", irq_oe, 1);

        // R1: no card, no start
        pwr_cmd_n = 0; idle(20);
        chk(vcc_en == 0, "R1 no card no supply", vcc_en, 0);
        pwr_cmd_n = 1; idle(3);

        // R2: card present clears interrupt
        pres_hi = 1; idle(5);
        chk(irq_drive_low == 0, "R2 card present irq", irq_drive_low, 0);

        // R5 / R4
        activate("R5 power-up order");
        rst_in = 1; @(negedge clk);
        chk(card_rst == 1, "R4 rst follows high", card_rst, 1);
        rst_in = 0; @(negedge clk);
        chk(card_rst == 0, "R4 rst follows low", card_rst, 0);
        chk(irq_drive_low == 0, "R3 no fault irq", irq_drive_low, 0);

        // R6 normal stop
        push_down("R6 shutdown order");
        pwr_cmd_n = 1;
        wait_snap(4'b0000, 200, "R6 reach idle");
        idle(2);
        chk(exp_q.size() == 0, "R6 all steps seen", exp_q.size(), 0);
        chk(irq_drive_low == 0, "R6 normal stop no irq", irq_drive_low, 0);

        // R8 power-down
        pwr_down = 1; idle(4);
        chk(pd_mode == 1, "R8 pd when idle", pd_mode, 1);
        pwr_down = 0; idle(3);
        activate("R8 power-up");
        pwr_down = 1; idle(6);
        chk(pd_mode == 0, "R8 pd ignored in session", pd_mode, 0);
        chk(vcc_en == 1, "R8 supply kept", vcc_en, 1);
        pwr_down = 0;

        // R7 chip select freeze
        cs = 0; @(negedge clk);
        chk(irq_oe == 0, "R7 irq floats", irq_oe, 0);
        chk(host_path_en == 0, "R7 data path closed", host_path_en, 0);
        pwr_cmd_n = 1; idle(30);
        chk(vcc_en == 1, "R7 command frozen", vcc_en, 1);
        push_down("R7 shutdown after release");
        cs = 1;
        wait_snap(4'b0000, 200, "R7 reach idle");
        idle(2);

        // R3 over-current
        activate("R3 power-up");
        push_down("R3 fault shutdown");
        flt_ovc = 1;
        wait_snap(4'b0000, 200, "R3 reach idle");
        flt_ovc = 0;
        idle(2);
        chk(irq_drive_low == 1, "R3 fault irq", irq_drive_low, 1);

        // R11 re-arm
        idle(20);
        chk(vcc_en == 0, "R11 no restart while low", vcc_en, 0);
        pwr_cmd_n = 1; idle(3);
        chk(irq_drive_low == 0, "R2 presence after fault", irq_drive_low, 0);
        activate("R11 restart");
        chk(vcc_en == 1, "R11 restart supply", vcc_en, 1);
        push_down("R11 shutdown");
        pwr_cmd_n = 1;
        wait_snap(4'b0000, 200, "R11 reach idle");
        idle(2);

        // R10 active-low switch and removal
        pres_hi = 0; pres_lo_n = 0; idle(5);
        chk(irq_drive_low == 0, "R10 low switch present", irq_drive_low, 0);
        activate("R10 power-up");
        push_down("R10 removal shutdown");
        pres_lo_n = 1;
        wait_snap(4'b0000, 200, "R10 reach idle");
        idle(2);
        chk(irq_drive_low == 1, "R3 removal irq", irq_drive_low, 1);
        pwr_cmd_n = 1; idle(3);
        chk(irq_drive_low == 1, "R2 no card irq", irq_drive_low, 1);
        pres_hi = 1; idle(4);

        // R12 supply timeout
        supply_model = 0;
        push(4'b1000, "R12 timeout"); push(4'b1001, "R12 timeout");
        push(4'b0001, "R12 timeout"); push(4'b0000, "R12 timeout");
        pwr_cmd_n = 0;
        wait_snap(4'b0000, 400, "R12 reach idle");
        idle(2);
        chk(irq_drive_low == 1, "R12 timeout irq", irq_drive_low, 1);
        supply_model = 1;
        pwr_cmd_n = 1; idle(4);

        // R9 synchronous mode
        clk_mode_sync = 1; rst_in = 1;
        push_up("R9 power-up");
        pwr_cmd_n = 0;
        wait_snap(4'b1100, 200, "R9 io step");
        chk(card_rst == 1, "R9 rst direct at io step", card_rst, 1);
        chk(clk_from_strobe == 1, "R9 strobe clock", clk_from_strobe, 1);
        wait_snap(4'b1110, 200, "R9 clock step");
        push_down("R9 shutdown");
        pwr_cmd_n = 1;
        wait_snap(4'b0000, 200, "R9 reach idle");
        idle(2);
        chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    endtask

    initial begin
        prev_snap = 4'b0000;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule